// File: doc/BRIEF.md
# Guarded Halfword Store Unit

This block carries out a 16-bit store into a byte-addressed data memory. Each accepted request supplies an address, a data word, a guard word and a byte-order selection. The unit drives two byte-write ports, one for the address itself and one for the address plus one. It places the low halfword of the data on those ports in little-endian or big-endian order, as a runtime mode input selects.

Bit 0 of the guard word decides whether a request has any effect at all. When it is clear, the unit writes nothing and leaves its status untouched. An odd address counts as a misaligned store. Such a store writes nothing and sets a sticky status flag, which stays set until a clear pulse arrives. If trapping is enabled at that moment, a trap request is armed internally. It is released as a one-cycle exception pulse at the next interruptible-jump strobe. Halfword accesses that fall inside a configurable register-mapped window are not supported, so their byte writes are suppressed.

Top module: `halfword_store_unit`

## Requirements
- R1: Only bits 15:0 of the data operand are stored. Port 0 writes the address A given on `st_addr_i`, and port 1 writes A+1.
- R2: With `big_endian_i`=0, port 0 carries data bits 7:0 and port 1 carries bits 15:8.
- R3: With `big_endian_i`=1, port 0 carries data bits 15:8 and port 1 carries bits 7:0. For example, 0x44332211 stored at 0xD00 writes 0x22 to 0xD00 and 0x11 to 0xD01.
- R4: When bit 0 of `guard_i` is 0, the request causes no byte write, no change to the misaligned flag and no arming of a trap. Guard bits 31:1 are ignored.
- R5: A guarded-true request with address bit 0 set raises `mis_flag_o` at the following clock edge.
- R6: A misaligned store asserts neither write enable.
- R7: `mis_flag_o` stays set until `mis_clr_i` is pulsed; a clear then takes it to 0 at the next edge. A clear in the same cycle as a new misalignment leaves it set.
- R8: A misaligned store made while `trap_en_i`=1 arms a pending trap. `exc_req_o` stays low until an `ijmp_i` strobe. It then goes high for exactly one cycle, in the cycle after the strobe, and the pending trap is consumed.
- R9: A misaligned store made while `trap_en_i`=0 sets the flag but never produces `exc_req_o`.
- R10: A request is accepted in a cycle where `st_valid_i`=1. The write enables go high one clock after acceptance for one cycle, and no write occurs while `st_valid_i`=0.
- R11: An aligned address in [MMIO_BASE, MMIO_BASE+MMIO_SIZE) produces no write enable. Addresses just outside either end of that window are written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_addr_i | input | AW | Byte address A |
| st_data_i | input | 32 | Data operand, low halfword stored |
| guard_i | input | 32 | Guard word, bit 0 enables |
| big_endian_i | input | 1 | Byte order: 1 big, 0 little |
| trap_en_i | input | 1 | Trap on misaligned store enable |
| ijmp_i | input | 1 | Interruptible jump strobe |
| mis_clr_i | input | 1 | Clear pulse for the misaligned flag |
| wr0_addr_o | output | AW | Byte port 0 address (A) |
| wr0_data_o | output | 8 | Byte port 0 data |
| wr0_en_o | output | 1 | Byte port 0 write enable |
| wr1_addr_o | output | AW | Byte port 1 address (A+1) |
| wr1_data_o | output | 8 | Byte port 1 data |
| wr1_en_o | output | 1 | Byte port 1 write enable |
| mis_flag_o | output | 1 | Sticky misaligned-store flag |
| exc_req_o | output | 1 | Exception request pulse |

## Verification
The bench builds the unit with a 32-bit address and moves the register window down to 0xE00 with a size of 0x40. This puts the window next to the example stores at 0xD00, so the same 256-byte bench memory covers normal writes, the edge just below the window, the first and last window addresses, and the first address past it. With those values, both byte orders, guard suppression, the flag-clear race and the deferred trap can all be checked against memory contents and port values in a short run.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HALF_W  = 2 * BYTE_W;
  localparam int unsigned N_LANES = HALF_W / BYTE_W;

  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } byte_order_e;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/hst_lane_steer.sv
module hst_lane_steer
  import hst_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  byte_order_e       order_i,
  output byte_t             lane_o [N_LANES]
);
  // lane l is the byte at address A+l
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    localparam int unsigned LE_SRC = l;
    localparam int unsigned BE_SRC = N_LANES - 1 - l;
    always_comb begin
      if (order_i == ORDER_BIG) lane_o[l] = half_i[BE_SRC*BYTE_W +: BYTE_W];
      else                      lane_o[l] = half_i[LE_SRC*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/hst_win_check.sv
module hst_win_check #(
  parameter int unsigned    AW   = 32,
  parameter logic [AW-1:0]  BASE = '0,
  parameter logic [AW-1:0]  SIZE = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  if (SIZE == '0) begin : g_none
    assign hit_o = 1'b0;
  end else begin : g_win
    logic [AW-1:0] offs;
    assign offs  = addr_i - BASE;
    assign hit_o = (addr_i >= BASE) && (offs < SIZE);
  end
endmodule

// File: rtl/hst_fault_track.sv
module hst_fault_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mis_evt_i,
  input  logic trap_en_i,
  input  logic clr_i,
  input  logic ijmp_i,
  output logic flag_o,
  output logic exc_o
);
  logic flag_q, pend_q, exc_q;
  logic arm;

  assign arm = mis_evt_i & trap_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      // new event wins over clear
      flag_q <= mis_evt_i | (flag_q & ~clr_i);
      // arming in the strobe cycle keeps a trap for the next strobe
      pend_q <= arm | (pend_q & ~ijmp_i);
      exc_q  <= pend_q & ijmp_i;
    end
  end

  assign flag_o = flag_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/halfword_store_unit.sv
module halfword_store_unit
  import hst_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter logic [AW-1:0] MMIO_BASE = 32'hEFE0_0000,
  parameter logic [AW-1:0] MMIO_SIZE = 32'h0010_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [31:0]   st_data_i,
  input  logic [31:0]   guard_i,
  input  logic          big_endian_i,
  input  logic          trap_en_i,
  input  logic          ijmp_i,
  input  logic          mis_clr_i,
  output logic [AW-1:0] wr0_addr_o,
  output logic [7:0]    wr0_data_o,
  output logic          wr0_en_o,
  output logic [AW-1:0] wr1_addr_o,
  output logic [7:0]    wr1_data_o,
  output logic          wr1_en_o,
  output logic          mis_flag_o,
  output logic          exc_req_o
);
  logic unused_hi;
  assign unused_hi = ^{st_data_i[31:HALF_W], guard_i[31:1]};

  logic        take, misal, win_hit, do_write;
  byte_t       lane [N_LANES];
  byte_order_e order;

  assign take     = st_valid_i & guard_i[0];
  assign misal    = take & st_addr_i[0];
  assign do_write = take & ~st_addr_i[0] & ~win_hit;
  assign order    = byte_order_e'(big_endian_i);

  hst_lane_steer u_steer (
    .half_i  (st_data_i[HALF_W-1:0]),
    .order_i (order),
    .lane_o  (lane)
  );

  hst_win_check #(.AW(AW), .BASE(MMIO_BASE), .SIZE(MMIO_SIZE)) u_win (
    .addr_i (st_addr_i),
    .hit_o  (win_hit)
  );

  hst_fault_track u_fault (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mis_evt_i (misal),
    .trap_en_i (trap_en_i),
    .clr_i     (mis_clr_i),
    .ijmp_i    (ijmp_i),
    .flag_o    (mis_flag_o),
    .exc_o     (exc_req_o)
  );

  logic [AW-1:0] addr_q;
  byte_t         data_q [N_LANES];
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      for (int l = 0; l < N_LANES; l++) data_q[l] <= '0;
    end else begin
      en_q <= do_write;
      if (do_write) begin
        addr_q <= st_addr_i;
        for (int l = 0; l < N_LANES; l++) data_q[l] <= lane[l];
      end
    end
  end

  assign wr0_addr_o = addr_q;
  assign wr1_addr_o = addr_q + AW'(1);
  assign wr0_data_o = data_q[0];
  assign wr1_data_o = data_q[1];
  assign wr0_en_o   = en_q;
  assign wr1_en_o   = en_q;
endmodule

module hst_sva #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic [AW-1:0] st_addr_i,
  input logic [31:0]   st_data_i,
  input logic [31:0]   guard_i,
  input logic          big_endian_i,
  input logic          ijmp_i,
  input logic          mis_clr_i,
  input logic [AW-1:0] wr0_addr_o,
  input logic [7:0]    wr0_data_o,
  input logic          wr0_en_o,
  input logic [AW-1:0] wr1_addr_o,
  input logic [7:0]    wr1_data_o,
  input logic          wr1_en_o,
  input logic          mis_flag_o,
  input logic          exc_req_o
);
  a_r1_port1_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1_en_o |-> wr1_addr_o == wr0_addr_o + AW'(1));
  a_r2_little_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && guard_i[0] && !st_addr_i[0] && !big_endian_i) |=>
      (!wr0_en_o || (wr0_data_o == $past(st_data_i[7:0]) && wr1_data_o == $past(st_data_i[15:8]))));
  a_r3_big_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && guard_i[0] && !st_addr_i[0] && big_endian_i) |=>
      (!wr0_en_o || (wr0_data_o == $past(st_data_i[15:8]) && wr1_data_o == $past(st_data_i[7:0]))));
  a_r4_guard_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !guard_i[0]) |=> (!wr0_en_o && !wr1_en_o));
  a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && guard_i[0] && st_addr_i[0]) |=> mis_flag_o);
  a_r6_misal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_addr_i[0]) |=> (!wr0_en_o && !wr1_en_o));
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mis_flag_o && !mis_clr_i) |=> mis_flag_o);
  a_r8_exc_after_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_req_o) |-> $past(ijmp_i));
  a_r10_no_valid_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i |=> !wr0_en_o);
endmodule

bind halfword_store_unit hst_sva #(.AW(AW)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_valid_i   (st_valid_i),
  .st_addr_i    (st_addr_i),
  .st_data_i    (st_data_i),
  .guard_i      (guard_i),
  .big_endian_i (big_endian_i),
  .ijmp_i       (ijmp_i),
  .mis_clr_i    (mis_clr_i),
  .wr0_addr_o   (wr0_addr_o),
  .wr0_data_o   (wr0_data_o),
  .wr0_en_o     (wr0_en_o),
  .wr1_addr_o   (wr1_addr_o),
  .wr1_data_o   (wr1_data_o),
  .wr1_en_o     (wr1_en_o),
  .mis_flag_o   (mis_flag_o),
  .exc_req_o    (exc_req_o)
);

// File: tb/halfword_store_unit_tb.sv
module halfword_store_unit_tb;
  localparam int unsigned   AW   = 32;
  localparam logic [AW-1:0] WBASE = 32'h0000_0E00;
  localparam logic [AW-1:0] WSIZE = 32'h0000_0040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [31:0]   st_data = '0;
  logic [31:0]   guard = '0;
  logic          be = 1'b0;
  logic          trap_en = 1'b0;
  logic          ijmp = 1'b0;
  logic          mis_clr = 1'b0;
  logic [AW-1:0] wr0_addr, wr1_addr;
  logic [7:0]    wr0_data, wr1_data;
  logic          wr0_en, wr1_en, mis_flag, exc_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  halfword_store_unit #(.AW(AW), .MMIO_BASE(WBASE), .MMIO_SIZE(WSIZE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_addr_i(st_addr),
    .st_data_i(st_data), .guard_i(guard), .big_endian_i(be), .trap_en_i(trap_en),
    .ijmp_i(ijmp), .mis_clr_i(mis_clr),
    .wr0_addr_o(wr0_addr), .wr0_data_o(wr0_data), .wr0_en_o(wr0_en),
    .wr1_addr_o(wr1_addr), .wr1_data_o(wr1_data), .wr1_en_o(wr1_en),
    .mis_flag_o(mis_flag), .exc_req_o(exc_req)
  );

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      if (wr0_en) mem[wr0_addr[7:0]] <= wr0_data;
      if (wr1_en) mem[wr1_addr[7:0]] <= wr1_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one request cycle; on return the registered outputs are visible
  task automatic store(input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] g,
                       input logic order, input logic vld);
    @(negedge clk);
    st_valid = vld; st_addr = a; st_data = d; guard = g; be = order;
    @(negedge clk);
    st_valid = 1'b0; guard = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulse_ijmp();
    @(negedge clk); ijmp = 1'b1;
    @(negedge clk); ijmp = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset wr_en", {31'd0, wr0_en | wr1_en}, 32'd0);
    check("R5 reset flag", {31'd0, mis_flag}, 32'd0);
    check("R8 reset exc", {31'd0, exc_req}, 32'd0);
  endtask

  task automatic t_big_endian();
    store(32'hD00, 32'h4433_2211, 32'h1, 1'b1, 1'b1);
    check("R10 en one clock after accept", {31'd0, wr0_en & wr1_en}, 32'd1);
    check("R1 port0 addr", wr0_addr, 32'hD00);
    check("R1 port1 addr", wr1_addr, 32'hD01);
    check("R3 port0 data", {24'd0, wr0_data}, 32'h22);
    check("R3 port1 data", {24'd0, wr1_data}, 32'h11);
    store(32'hD02, 32'hAABB_CCDD, 32'h1, 1'b1, 1'b1);
    settle();
    check("R10 single cycle enable", {31'd0, wr0_en}, 32'd0);
    check("R3 mem D00", {24'd0, mem[8'h00]}, 32'h22);
    check("R3 mem D01", {24'd0, mem[8'h01]}, 32'h11);
    check("R3 mem D02", {24'd0, mem[8'h02]}, 32'hCC);
    check("R3 mem D03", {24'd0, mem[8'h03]}, 32'hDD);
  endtask

  task automatic t_little_endian();
    store(32'hD04, 32'h4433_2211, 32'h1, 1'b0, 1'b1);
    check("R2 port0 data", {24'd0, wr0_data}, 32'h11);
    check("R2 port1 data", {24'd0, wr1_data}, 32'h22);
    store(32'hD06, 32'hFFFF_A55A, 32'h3, 1'b0, 1'b1);
    settle();
    check("R1 mem D04", {24'd0, mem[8'h04]}, 32'h11);
    check("R1 mem D05", {24'd0, mem[8'h05]}, 32'h22);
    check("R2 mem D06", {24'd0, mem[8'h06]}, 32'h5A);
    check("R2 mem D07", {24'd0, mem[8'h07]}, 32'hA5);
  endtask

  task automatic t_guard();
    trap_en = 1'b1;
    store(32'hD10, 32'h0000_1234, 32'hFFFF_FFFE, 1'b0, 1'b1);
    check("R4 guard false no write", {31'd0, wr0_en | wr1_en}, 32'd0);
    store(32'hD11, 32'h0000_1234, 32'hFFFF_FFFE, 1'b0, 1'b1);
    check("R4 guard false no flag", {31'd0, mis_flag}, 32'd0);
    pulse_ijmp();
    check("R4 guard false no trap", {31'd0, exc_req}, 32'd0);
    settle();
    check("R4 mem D10 untouched", {24'd0, mem[8'h10]}, 32'h00);
    trap_en = 1'b0;
  endtask

  task automatic t_valid_low();
    store(32'hD20, 32'h0000_BEEF, 32'h1, 1'b0, 1'b0);
    check("R10 valid low no write", {31'd0, wr0_en | wr1_en}, 32'd0);
    settle();
    check("R10 mem D20 untouched", {24'd0, mem[8'h20]}, 32'h00);
  endtask

  task automatic t_misal_no_trap();
    trap_en = 1'b0;
    store(32'hD31, 32'h0000_7788, 32'h1, 1'b0, 1'b1);
    check("R6 misaligned no write", {31'd0, wr0_en | wr1_en}, 32'd0);
    check("R5 flag set", {31'd0, mis_flag}, 32'd1);
    pulse_ijmp();
    check("R9 no exception without trap enable", {31'd0, exc_req}, 32'd0);
    settle();
    check("R7 flag sticky", {31'd0, mis_flag}, 32'd1);
    check("R6 mem D31 untouched", {24'd0, mem[8'h31]}, 32'h00);
    @(negedge clk); mis_clr = 1'b1;
    @(negedge clk); mis_clr = 1'b0;
    check("R7 clear", {31'd0, mis_flag}, 32'd0);
  endtask

  task automatic t_trap();
    trap_en = 1'b1;
    store(32'hD41, 32'h0000_0001, 32'h1, 1'b1, 1'b1);
    trap_en = 1'b0;
    check("R8 no immediate exception", {31'd0, exc_req}, 32'd0);
    settle(); settle();
    check("R8 still deferred", {31'd0, exc_req}, 32'd0);
    pulse_ijmp();
    check("R8 exception after jump", {31'd0, exc_req}, 32'd1);
    settle();
    check("R8 one cycle pulse", {31'd0, exc_req}, 32'd0);
    pulse_ijmp();
    check("R8 pending consumed", {31'd0, exc_req}, 32'd0);
    // re-arm
    trap_en = 1'b1;
    store(32'hD43, 32'h0, 32'h1, 1'b0, 1'b1);
    trap_en = 1'b0;
    pulse_ijmp();
    check("R8 rearmed exception", {31'd0, exc_req}, 32'd1);
  endtask

  task automatic t_clr_race();
    check("R7 flag set before race", {31'd0, mis_flag}, 32'd1);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'hD51; guard = 32'h1; mis_clr = 1'b1;
    @(negedge clk);
    st_valid = 1'b0; guard = '0; mis_clr = 1'b0;
    check("R7 clear with new misalign keeps flag", {31'd0, mis_flag}, 32'd1);
    @(negedge clk); mis_clr = 1'b1;
    @(negedge clk); mis_clr = 1'b0;
    check("R7 clear after race", {31'd0, mis_flag}, 32'd0);
  endtask

  task automatic t_window();
    store(32'hE00, 32'h0000_1111, 32'h1, 1'b0, 1'b1);
    check("R11 window base no write", {31'd0, wr0_en | wr1_en}, 32'd0);
    store(32'hE3E, 32'h0000_2222, 32'h1, 1'b0, 1'b1);
    check("R11 window top no write", {31'd0, wr0_en | wr1_en}, 32'd0);
    store(32'hDFE, 32'h0000_3344, 32'h1, 1'b0, 1'b1);
    check("R11 below window writes", {31'd0, wr0_en & wr1_en}, 32'd1);
    store(32'hE40, 32'h0000_5566, 32'h1, 1'b0, 1'b1);
    check("R11 past window writes", {31'd0, wr0_en & wr1_en}, 32'd1);
    settle();
    check("R11 mem E00 untouched", {24'd0, mem[8'h00]}, 32'h22);
    check("R11 mem DFE", {24'd0, mem[8'hFE]}, 32'h44);
    check("R11 mem E40", {24'd0, mem[8'h40]}, 32'h66);
    check("R11 flag unchanged", {31'd0, mis_flag}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_big_endian();
    t_little_endian();
    t_guard();
    t_valid_low();
    t_misal_no_trap();
    t_trap();
    t_clr_race();
    t_window();
    repeat (2) settle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule